// File: doc/BRIEF.md
# Command-Driven I2C Bus Master

This block is a master-side I2C bus engine that never runs a whole transfer by itself. Software picks one bus primitive through a 3-bit command field and fires it with a one-cycle trigger. The primitive is one of these: open the bus, close it, move one byte in either direction, answer with an acknowledge bit, or sample the acknowledge bit that a slave returns. While the primitive runs the engine reports busy. When it ends, busy drops, an interrupt flag rises in the same cycle and a 3-bit completion code says what happened. Software acknowledges the interrupt, which also wipes the code.

Both bus lines are open drain, so the block produces only pull-low enables for SCL and SDA. It reads the resolved SDA level back to receive data and acknowledge bits. The bus clock comes from a run-time half-period setting. Each SCL pulse is one low half followed by one high half. SDA is never moved on the same clock edge as SCL. Arbitration between several masters and slaves holding SCL low are not handled.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset the command field reads 0, busy, interrupt and completion code read 0, and neither line is pulled low.
- R2: The command values are 0 open (start), 1 close (stop), 2 send byte, 3 read byte, 4 send ACK, 5 send NAK, 6 sample acknowledge and 7 unused. An accepted trigger makes busy read 1 from the next clock edge. Busy stays 1 for exactly H x max(half_i,2) cycles, where H is 4 for open, 3 for close, 17 for a byte and 3 for each single-bit command.
- R3: On the edge where busy falls, the interrupt flag rises. The completion code then reads 1 open, 2 close, 3 byte sent, 4 byte read, 5 ACK or NAK sent, 6 ACK seen or 7 NAK seen.
- R4: A clear pulse while idle makes the interrupt flag and the completion code read 0 after the next edge. A completion in the same cycle takes precedence over the clear.
- R5: A trigger with command 7, or any trigger while busy, starts nothing and leaves the running operation, the flags and the lines as they were. A command write in that cycle still updates the command field.
- R6: An open pulls SDA low while SCL is released and ends with both lines pulled low. A close releases SDA while SCL is released and ends with both lines released.
- R7: Send byte takes tx_byte_i at the trigger and puts it on SDA MSB first, one bit per SCL pulse (SDA low for a 0). A trailing low half then holds the last bit.
- R8: Read byte releases SDA. It samples SDA in the last cycle of each SCL high half and shifts the samples MSB first into rx_byte_o.
- R9: Send ACK pulls SDA low for one SCL pulse. Send NAK leaves SDA released for that pulse.
- R10: Sample acknowledge releases SDA for one SCL pulse. It ends with code 6 when SDA was low at the sample point and 7 when SDA was high.
- R11: SDA never changes on a clock edge where SCL changes. SDA changes while SCL is released only inside an open or a close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Write strobe for the command field |
| cmd_i | input | 3 | Command value written with cmd_we_i |
| trig_i | input | 1 | Start the command (the value being written this cycle, if any) |
| irq_clr_i | input | 1 | Acknowledge the interrupt and wipe the completion code |
| tx_byte_i | input | BYTE_W | Byte to send, taken at the trigger |
| half_i | input | DIV_W | Clock cycles per SCL half period (values below 2 act as 2) |
| sda_i | input | 1 | Resolved SDA line level |
| cmd_o | output | 3 | Current command field |
| busy_o | output | 1 | Operation in progress |
| irq_o | output | 1 | Completion interrupt flag |
| status_o | output | 3 | Completion code |
| rx_byte_o | output | BYTE_W | Last byte read from the bus |
| scl_low_o | output | 1 | Pull SCL low |
| sda_low_o | output | 1 | Pull SDA low |

## Verification
A wrong phase counter or half-period count shows up at busy_o at once: busy falls early or late, and that is visible on the first completed command. A wrong bit index or shift direction shows up as a wrong SDA level at an SCL rising edge in the same operation, and as a wrong rx_byte_o or completion code when the interrupt rises. A slip in the edge ordering between the two lines appears on the bus as a false open or close, at the edge where it happens. The bench counts these events per operation.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

    typedef enum logic [2:0] {
        CMD_START  = 3'd0,
        CMD_STOP   = 3'd1,
        CMD_WRITE  = 3'd2,
        CMD_READ   = 3'd3,
        CMD_ACK    = 3'd4,
        CMD_NAK    = 3'd5,
        CMD_GETACK = 3'd6,
        CMD_RSVD   = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        ST_NONE    = 3'd0,
        ST_START   = 3'd1,
        ST_STOP    = 3'd2,
        ST_SENT    = 3'd3,
        ST_RCVD    = 3'd4,
        ST_ACKSENT = 3'd5,
        ST_GOTACK  = 3'd6,
        ST_GOTNAK  = 3'd7
    } status_e;

    // Number of SCL half periods an operation occupies.
    function automatic int halves(cmd_e op, int byte_w);
        case (op)
            CMD_START:            return 4;
            CMD_STOP:             return 3;
            CMD_WRITE, CMD_READ:  return 2 * byte_w + 1;
            default:              return 3;
        endcase
    endfunction

endpackage

// File: rtl/i2cq_half_timer.sv
module i2cq_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit  = (half_i < DIV_W'(2)) ? DIV_W'(2) : half_i;
        tick_o = en_i && (cnt_q == limit - DIV_W'(1));
        cnt_d  = cnt_q;
        if (!en_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/i2cq_drive.sv
// Line drive wanted during one half period of one operation.
module i2cq_drive
    import i2cq_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PH_W   = 5
) (
    input  cmd_e              op_i,
    input  logic [PH_W-1:0]   phase_i,
    input  logic [BYTE_W-1:0] tx_i,
    output logic              scl_low_o,
    output logic              sda_low_o
);
    int  nbits;
    int  idx;
    logic tail;

    always_comb begin
        nbits     = (op_i == CMD_WRITE || op_i == CMD_READ) ? BYTE_W : 1;
        tail      = int'(phase_i) >= 2 * nbits;
        idx       = tail ? nbits - 1 : int'(phase_i) / 2;
        scl_low_o = 1'b0;
        sda_low_o = 1'b0;
        case (op_i)
            CMD_START: begin
                case (phase_i)
                    PH_W'(0): begin scl_low_o = 1'b1; sda_low_o = 1'b0; end
                    PH_W'(1): begin scl_low_o = 1'b0; sda_low_o = 1'b0; end
                    PH_W'(2): begin scl_low_o = 1'b0; sda_low_o = 1'b1; end
                    default:  begin scl_low_o = 1'b1; sda_low_o = 1'b1; end
                endcase
            end
            CMD_STOP: begin
                case (phase_i)
                    PH_W'(0): begin scl_low_o = 1'b1; sda_low_o = 1'b1; end
                    PH_W'(1): begin scl_low_o = 1'b0; sda_low_o = 1'b1; end
                    default:  begin scl_low_o = 1'b0; sda_low_o = 1'b0; end
                endcase
            end
            default: begin
                scl_low_o = tail || !phase_i[0];
                case (op_i)
                    CMD_WRITE: sda_low_o = !tx_i[BYTE_W-1-idx];
                    CMD_ACK:   sda_low_o = 1'b1;
                    default:   sda_low_o = 1'b0;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2cq_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_we_i,
    input  logic [2:0]        cmd_i,
    input  logic              trig_i,
    input  logic              irq_clr_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  logic [DIV_W-1:0]  half_i,
    input  logic              sda_i,
    output logic [2:0]        cmd_o,
    output logic              busy_o,
    output logic              irq_o,
    output logic [2:0]        status_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              scl_low_o,
    output logic              sda_low_o
);
    localparam int PH_W = $clog2(2 * BYTE_W + 2);

    typedef struct packed {
        logic [2:0]        cmd;
        logic              busy;
        cmd_e              op;
        logic [PH_W-1:0]   phase;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] rx;
        logic              ack_low;
        logic              irq;
        status_e           status;
        logic              scl_low;
        logic              sda_low;
    } state_t;

    state_t     d, q;
    logic [2:0] eff_cmd;
    logic       tick;
    logic       cur_scl, cur_sda, nxt_scl, nxt_sda, ent_scl, ent_sda;
    logic       last, smp_phase;
    status_e    done_status;

    i2cq_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (q.busy),
        .half_i (half_i),
        .tick_o (tick)
    );

    // Drive for the running phase, the following phase and a fresh command.
    i2cq_drive #(.BYTE_W(BYTE_W), .PH_W(PH_W)) u_drv_cur (
        .op_i (q.op), .phase_i (q.phase), .tx_i (q.tx),
        .scl_low_o (cur_scl), .sda_low_o (cur_sda)
    );
    i2cq_drive #(.BYTE_W(BYTE_W), .PH_W(PH_W)) u_drv_nxt (
        .op_i (q.op), .phase_i (q.phase + PH_W'(1)), .tx_i (q.tx),
        .scl_low_o (nxt_scl), .sda_low_o (nxt_sda)
    );
    i2cq_drive #(.BYTE_W(BYTE_W), .PH_W(PH_W)) u_drv_ent (
        .op_i (cmd_e'(eff_cmd)), .phase_i ('0), .tx_i (tx_byte_i),
        .scl_low_o (ent_scl), .sda_low_o (ent_sda)
    );

    always_comb begin
        eff_cmd   = cmd_we_i ? cmd_i : q.cmd;
        last      = int'(q.phase) == halves(q.op, BYTE_W) - 1;
        smp_phase = q.phase[0] && (q.op == CMD_READ || q.op == CMD_GETACK);
        case (q.op)
            CMD_START:         done_status = ST_START;
            CMD_STOP:          done_status = ST_STOP;
            CMD_WRITE:         done_status = ST_SENT;
            CMD_READ:          done_status = ST_RCVD;
            CMD_ACK, CMD_NAK:  done_status = ST_ACKSENT;
            default:           done_status = q.ack_low ? ST_GOTACK : ST_GOTNAK;
        endcase
    end

    always_comb begin
        d = q;
        if (cmd_we_i) begin
            d.cmd = cmd_i;
        end
        if (irq_clr_i) begin
            d.irq    = 1'b0;
            d.status = ST_NONE;
        end
        if (!q.busy) begin
            if (trig_i && eff_cmd != CMD_RSVD) begin
                d.busy    = 1'b1;
                d.op      = cmd_e'(eff_cmd);
                d.phase   = '0;
                d.tx      = tx_byte_i;
                d.scl_low = ent_scl;
                // SDA waits one cycle whenever SCL moves on this edge.
                d.sda_low = (ent_scl != q.scl_low) ? q.sda_low : ent_sda;
            end
        end else if (tick) begin
            if (smp_phase) begin
                if (q.op == CMD_READ) begin
                    d.rx = {q.rx[BYTE_W-2:0], sda_i};
                end
                if (q.op == CMD_GETACK) begin
                    d.ack_low = !sda_i;
                end
            end
            if (last) begin
                d.busy   = 1'b0;
                d.irq    = 1'b1;
                d.status = done_status;
            end else begin
                d.phase   = q.phase + PH_W'(1);
                d.scl_low = nxt_scl;
                d.sda_low = (nxt_scl != q.scl_low) ? q.sda_low : nxt_sda;
            end
        end else begin
            d.scl_low = cur_scl;
            d.sda_low = cur_sda;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{cmd: 3'd0, busy: 1'b0, op: CMD_START, phase: '0,
                   tx: '0, rx: '0, ack_low: 1'b0, irq: 1'b0,
                   status: ST_NONE, scl_low: 1'b0, sda_low: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign cmd_o     = q.cmd;
    assign busy_o    = q.busy;
    assign irq_o     = q.irq;
    assign status_o  = q.status;
    assign rx_byte_o = q.rx;
    assign scl_low_o = q.scl_low;
    assign sda_low_o = q.sda_low;
endmodule

// File: rtl/i2cq_checker.sv
module i2cq_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       cmd_we_i,
    input logic [2:0] cmd_i,
    input logic       trig_i,
    input logic       irq_clr_i,
    input logic [2:0] cmd_o,
    input logic       busy_o,
    input logic       irq_o,
    input logic [2:0] status_o,
    input logic       scl_low_o,
    input logic       sda_low_o
);
    logic [2:0] sel;
    assign sel = cmd_we_i ? cmd_i : cmd_o;

    a_r2_trigger_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_i && !busy_o && sel != 3'd7) |=> busy_o);

    a_r5_reserved_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_i && !busy_o && sel == 3'd7) |=> !busy_o);

    a_r3_irq_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> irq_o);

    a_r3_code_on_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> (status_o != 3'd0));

    a_r4_clear_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_clr_i && !busy_o) |=> (!irq_o && status_o == 3'd0));

    a_r11_sda_holds_on_scl_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scl_low_o != $past(scl_low_o)) |-> (sda_low_o == $past(sda_low_o)));
endmodule

bind i2c_cmd_master i2cq_checker u_i2cq_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_we_i  (cmd_we_i),
    .cmd_i     (cmd_i),
    .trig_i    (trig_i),
    .irq_clr_i (irq_clr_i),
    .cmd_o     (cmd_o),
    .busy_o    (busy_o),
    .irq_o     (irq_o),
    .status_o  (status_o),
    .scl_low_o (scl_low_o),
    .sda_low_o (sda_low_o)
);

// File: tb/test_i2c_cmd_master.sv
`timescale 1ns/1ps
module test_i2c_cmd_master;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic       trig = 1'b0;
    logic       irq_clr = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic [7:0] half = 8'(HALF);
    logic [2:0] cmd_o, status_o;
    logic       busy_o, irq_o, scl_low_o, sda_low_o;
    logic [7:0] rx_byte_o;

    logic slave_low = 1'b0;
    logic slave_on = 1'b0;
    logic [7:0] slave_byte = 8'h00;
    int   slave_idx = -1;

    wire scl_line = ~scl_low_o;
    wire sda_line = ~(sda_low_o | slave_low);

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    i2c_cmd_master i_i2c_cmd_master (
        .clk_i (clk), .rst_ni (rst_n), .cmd_we_i (cmd_we), .cmd_i (cmd),
        .trig_i (trig), .irq_clr_i (irq_clr), .tx_byte_i (tx_byte),
        .half_i (half), .sda_i (sda_line), .cmd_o (cmd_o), .busy_o (busy_o),
        .irq_o (irq_o), .status_o (status_o), .rx_byte_o (rx_byte_o),
        .scl_low_o (scl_low_o), .sda_low_o (sda_low_o)
    );

    typedef struct {
        logic [2:0] st;
        logic       chk_rx;
        logic [7:0] rx;
        int         nb;
        logic [7:0] bits;
        int         dstart;
        int         dstop;
        string      tag;
    } exp_t;

    exp_t sb[$];
    logic cap[$];
    int   starts = 0, stops = 0, base_s = 0, base_p = 0;
    logic irq_prev = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bus monitor: SDA level at every SCL rise, plus open and close events.
    always @(posedge scl_line) cap.push_back(sda_line);
    always @(negedge sda_line) if (scl_line === 1'b1) starts++;
    always @(posedge sda_line) if (scl_line === 1'b1) stops++;

    // Slave model: next bit is placed on each SCL fall.
    always @(posedge scl_low_o) begin
        if (slave_on) begin
            if (slave_idx >= 0) begin
                slave_low = !slave_byte[slave_idx];
                slave_idx--;
            end else begin
                slave_low = 1'b0;
                slave_on  = 1'b0;
            end
        end
    end

    // Scoreboard monitor: compares each completion with the queued item.
    always @(negedge clk) begin
        if (!rst_n) begin
            cap.delete();
            base_s = starts;
            base_p = stops;
            irq_prev = 1'b0;
        end else begin
            if (irq_o && !irq_prev) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R3 unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    logic [7:0] v;
                    e = sb.pop_front();
                    v = 8'h00;
                    foreach (cap[i]) v = {v[6:0], cap[i]};
                    chk(status_o == e.st, "R3 completion code", status_o, e.st);
                    if (e.chk_rx) chk(rx_byte_o == e.rx, "R8 received byte", rx_byte_o, e.rx);
                    chk(cap.size() == e.nb, {e.tag, " SCL pulse count"}, cap.size(), e.nb);
                    chk(v == e.bits, {e.tag, " SDA bits at SCL rise"}, v, e.bits);
                    chk(starts - base_s == e.dstart, "R6/R11 open events", starts - base_s, e.dstart);
                    chk(stops - base_p == e.dstop, "R6/R11 close events", stops - base_p, e.dstop);
                end
                cap.delete();
                base_s = starts;
                base_p = stops;
            end
            irq_prev = irq_o;
        end
    end

    // Driver: queue the expectation, fire the command, time busy, clear.
    task automatic run_op(input logic [2:0] c, input logic [7:0] tx,
                          input bit use_slave, input logic [7:0] slv, input int sl_bits,
                          input logic [2:0] st, input logic chk_rx, input int nb,
                          input logic [7:0] bits, input int ds, input int dp,
                          input int nhalves, input bit poke, input string tag);
        exp_t e;
        int cnt;
        e.st = st; e.chk_rx = chk_rx; e.rx = slv; e.nb = nb; e.bits = bits;
        e.dstart = ds; e.dstop = dp; e.tag = tag;
        sb.push_back(e);
        if (use_slave) begin
            slave_byte = slv;
            slave_idx  = sl_bits - 1;
            slave_low  = !slv[slave_idx];
            slave_idx--;
            slave_on   = 1'b1;
        end
        cmd_we = 1'b1; cmd = c; tx_byte = tx; trig = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0; trig = 1'b0; tx_byte = ~tx;
        chk(busy_o == 1'b1, "R2 busy after trigger", busy_o, 1);
        cnt = 0;
        while (busy_o && cnt < 1000) begin
            if (poke && cnt == 20) begin
                cmd_we = 1'b1; cmd = 3'd0; trig = 1'b1;
            end else begin
                cmd_we = 1'b0; trig = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        cmd_we = 1'b0; trig = 1'b0;
        chk(cnt == nhalves * HALF, "R2 busy duration", cnt, nhalves * HALF);
        chk(irq_o == 1'b1, "R3 interrupt with busy fall", irq_o, 1);
        if (poke) chk(cmd_o == 3'd0, "R5 field written while busy", cmd_o, 0);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq_o == 1'b0, "R4 interrupt cleared", irq_o, 0);
        chk(status_o == 3'd0, "R4 code cleared", status_o, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic sl_prev, sd_prev;
        repeat (3) @(negedge clk);
        chk(cmd_o == 3'd0, "R1 command field", cmd_o, 0);
        chk(!busy_o && !irq_o && status_o == 3'd0, "R1 flags", {busy_o, irq_o, status_o}, 0);
        chk(!scl_low_o && !sda_low_o, "R1 lines released", {scl_low_o, sda_low_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // open from idle: one SCL rise with SDA high, one open event
        run_op(3'd0, 8'h00, 0, 8'h00, 0, 3'd1, 0, 1, 8'h01, 1, 0, 4, 0, "R6");
        chk(scl_low_o && sda_low_o, "R6 lines after open", {scl_low_o, sda_low_o}, 3);
        run_op(3'd2, 8'hA5, 0, 8'h00, 0, 3'd3, 0, 8, 8'hA5, 0, 0, 17, 0, "R7");
        run_op(3'd6, 8'h00, 1, 8'h00, 1, 3'd6, 0, 1, 8'h00, 0, 0, 3, 0, "R10");
        // send byte with a stray trigger in mid-flight
        run_op(3'd2, 8'h3C, 0, 8'h00, 0, 3'd3, 0, 8, 8'h3C, 0, 0, 17, 1, "R5");
        run_op(3'd6, 8'h00, 1, 8'h01, 1, 3'd7, 0, 1, 8'h01, 0, 0, 3, 0, "R10");
        run_op(3'd3, 8'h00, 1, 8'h96, 8, 3'd4, 1, 8, 8'h96, 0, 0, 17, 0, "R8");
        run_op(3'd4, 8'h00, 0, 8'h00, 0, 3'd5, 0, 1, 8'h00, 0, 0, 3, 0, "R9");
        run_op(3'd3, 8'h00, 1, 8'h5A, 8, 3'd4, 1, 8, 8'h5A, 0, 0, 17, 0, "R8");
        run_op(3'd5, 8'h00, 0, 8'h00, 0, 3'd5, 0, 1, 8'h01, 0, 0, 3, 0, "R9");

        // unused command value
        sl_prev = scl_low_o; sd_prev = sda_low_o;
        cmd_we = 1'b1; cmd = 3'd7; trig = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0; trig = 1'b0;
        chk(busy_o == 1'b0, "R5 unused command not started", busy_o, 0);
        chk(cmd_o == 3'd7, "R5 field written", cmd_o, 7);
        repeat (10) @(negedge clk);
        chk(!irq_o && status_o == 3'd0, "R5 no completion", {irq_o, status_o}, 0);
        chk(scl_low_o == sl_prev && sda_low_o == sd_prev, "R5 lines untouched",
            {scl_low_o, sda_low_o}, {sl_prev, sd_prev});

        run_op(3'd1, 8'h00, 0, 8'h00, 0, 3'd2, 0, 1, 8'h00, 0, 1, 3, 0, "R6");
        chk(!scl_low_o && !sda_low_o, "R6 lines after close", {scl_low_o, sda_low_o}, 0);
        run_op(3'd0, 8'h00, 0, 8'h00, 0, 3'd1, 0, 1, 8'h01, 1, 0, 4, 0, "R6");
        run_op(3'd2, 8'h81, 0, 8'h00, 0, 3'd3, 0, 8, 8'h81, 0, 0, 17, 0, "R7");
        run_op(3'd1, 8'h00, 0, 8'h00, 0, 3'd2, 0, 1, 8'h00, 0, 1, 3, 0, "R11");

        chk(sb.size() == 0, "R3 all completions seen", sb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule